// File: doc/BRIEF.md
# Programmable FIFO threshold flag unit

This block sits beside a FIFO's storage and pointer logic. It owns the two programmable thresholds, one for "nearly empty" and one for "nearly full", and turns the FIFO's fill information into two flags. The nearly-empty flag is generated in the read clock domain from the stored-word count. The nearly-full flag is generated in the write clock domain from the free space.

A single load-control input, sampled during master reset, fixes two things at once: the default threshold value and the method used to program the thresholds afterwards. With load low, both thresholds default to 127 and programming is word-wide over the data bus. With load high, both default to 1023 and programming is one bit per write-clock edge. Whichever method is fixed, the read side can fetch both thresholds word-wide through the readback bus. Partial reset restarts the programming and readback sequences but keeps the thresholds and the method. While load is high, the block also stops the FIFO's pointer-advance strobes, so that programming cycles never move data.

Top module: `fifo_thresh_flags`

## Requirements
- R1: While master reset is high, the load-control level picks the mode and the defaults. Load low gives word-wide mode with both thresholds at 127. Load high gives bit-serial mode with both thresholds at 1023. Master reset also clears the readback output to zero.
- R2: In word-wide mode, each write-clock edge with write enable and load both high stores the data bus into a threshold. The first store after any reset goes to the nearly-empty threshold, and later stores alternate between the nearly-full and nearly-empty thresholds.
- R3: In bit-serial mode, each write-clock edge with serial enable and load both high stores the serial input into bit k of a 2*OFS_W bit chain, then advances k. Chain bits 0..OFS_W-1 are nearly-empty bits 0 upward, and bits OFS_W..2*OFS_W-1 are nearly-full bits 0 upward. After the last bit, k wraps to 0.
- R4: Strobes of the method that was not selected change neither threshold. Neither does any write-clock edge with load low.
- R5: Each read-clock edge with read enable and load both high registers a threshold onto the readback bus. The first readback after any reset returns the nearly-empty threshold, and later readbacks alternate. In every other cycle the readback bus holds its value. This works in both modes.
- R6: The nearly-empty flag is registered on the read clock. It is high when the read-side word count is at or below the nearly-empty threshold.
- R7: The nearly-full flag is registered on the write clock. It is high when DEPTH minus the write-side word count is at or below the nearly-full threshold.
- R8: Partial reset keeps both thresholds and the mode. It restarts the word-wide store order, the readback order and the serial bit index k at their first positions.
- R9: The write-advance output equals write enable with load low, and the read-advance output equals read enable with load low.
- R10: While master reset or partial reset is high, the nearly-empty flag reads 1 and the nearly-full flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, synchronous in each domain |
| prst | input | 1 | Partial reset, active high, synchronous in each domain |
| ld | input | 1 | Load control; selects mode and defaults during master reset |
| sen | input | 1 | Serial enable |
| sin | input | 1 | Serial data bit |
| wen | input | 1 | Write enable |
| din | input | OFS_W | Word-wide threshold data |
| ren | input | 1 | Read enable |
| wr_level | input | LVL_W | Stored-word count seen by the write domain |
| rd_level | input | LVL_W | Stored-word count seen by the read domain |
| almost_empty | output | 1 | Nearly-empty flag, read domain |
| almost_full | output | 1 | Nearly-full flag, write domain |
| rb_data | output | OFS_W | Threshold readback data |
| wr_advance | output | 1 | Write pointer may advance |
| rd_advance | output | 1 | Read pointer may advance |

## Verification
Each kind of wrong internal state shows up at a different place. A wrong threshold bit shows on the next readback of that register, and it also moves the edge of a flag during a level sweep. A stuck or out-of-phase store or readback toggle swaps which register a value lands in, and that is visible within two readbacks. A serial index that partial reset failed to clear puts bits into the wrong positions, which shows on the readback that follows a short serial run. A mode bit lost on partial reset shows as soon as a strobe of the wrong method changes a threshold.

// File: rtl/fifo_thr_pkg.sv
package fifo_thr_pkg;
   typedef enum logic {
      MODE_WORD = 1'b0,
      MODE_BIT  = 1'b1
   } load_mode_e;

   typedef enum logic {
      PICK_AE = 1'b0,
      PICK_AF = 1'b1
   } ofs_pick_e;
endpackage

// File: rtl/fthr_ofs_regs.sv
module fthr_ofs_regs
   import fifo_thr_pkg::*;
#(
   parameter int OFS_W    = 14,
   parameter int DFLT_LO  = 127,
   parameter int DFLT_HI  = 1023
) (
   input  logic             wclk,
   input  logic             mrst,
   input  logic             prst,
   input  logic             ld,
   input  logic             sen,
   input  logic             sin,
   input  logic             wen,
   input  logic [OFS_W-1:0] din,
   output logic [OFS_W-1:0] ae_ofs,
   output logic [OFS_W-1:0] af_ofs,
   output load_mode_e       mode
);
   localparam int CHAIN = 2 * OFS_W;
   localparam int IDX_W = $clog2(CHAIN);

   logic [IDX_W-1:0] bit_idx;
   ofs_pick_e        pick;
   logic [CHAIN-1:0] chain_cur;
   logic [CHAIN-1:0] bit_hit;
   logic [CHAIN-1:0] chain_nxt;
   logic             ser_stb;
   logic             par_stb;

   assign chain_cur = {af_ofs, ae_ofs};

   for (genvar i = 0; i < CHAIN; i++) begin : g_hit
      assign bit_hit[i] = (bit_idx == IDX_W'(i));
   end

   assign chain_nxt = (chain_cur & ~bit_hit) | (bit_hit & {CHAIN{sin}});
   assign ser_stb   = ld && sen && (mode == MODE_BIT);
   assign par_stb   = ld && wen && (mode == MODE_WORD);

   always_ff @(posedge wclk) begin
      if (mrst) begin
         mode    <= ld ? MODE_BIT : MODE_WORD;
         ae_ofs  <= ld ? OFS_W'(DFLT_HI) : OFS_W'(DFLT_LO);
         af_ofs  <= ld ? OFS_W'(DFLT_HI) : OFS_W'(DFLT_LO);
         pick    <= PICK_AE;
         bit_idx <= '0;
      end else if (prst) begin
         pick    <= PICK_AE;
         bit_idx <= '0;
      end else if (ser_stb) begin
         ae_ofs  <= chain_nxt[OFS_W-1:0];
         af_ofs  <= chain_nxt[CHAIN-1:OFS_W];
         bit_idx <= (bit_idx == IDX_W'(CHAIN - 1)) ? '0 : bit_idx + 1'b1;
      end else if (par_stb) begin
         if (pick == PICK_AE) begin
            ae_ofs <= din;
            pick   <= PICK_AF;
         end else begin
            af_ofs <= din;
            pick   <= PICK_AE;
         end
      end
   end

   // R4: no load, no change
   a_r4_idle_keeps: assert property (@(posedge wclk) disable iff (mrst)
      !ld |=> ($stable(ae_ofs) && $stable(af_ofs)));
   // R4: word strobe ignored in bit-serial mode
   a_r4_bitmode_ignores_wen: assert property (@(posedge wclk) disable iff (mrst)
      (mode == MODE_BIT && !sen) |=> ($stable(ae_ofs) && $stable(af_ofs)));
   // R4: serial strobe ignored in word mode
   a_r4_wordmode_ignores_sen: assert property (@(posedge wclk) disable iff (mrst)
      (mode == MODE_WORD && !wen) |=> ($stable(ae_ofs) && $stable(af_ofs)));
   // R8: mode only changes under master reset
   a_r8_mode_kept: assert property (@(posedge wclk) disable iff (mrst)
      !prst |=> $stable(mode));
   a_r8_prst_keeps_ofs: assert property (@(posedge wclk) disable iff (mrst)
      prst |=> ($stable(ae_ofs) && $stable(af_ofs)));
   // R3: index stays inside chain
   a_r3_idx_range: assert property (@(posedge wclk) disable iff (mrst)
      bit_idx < IDX_W'(CHAIN));
endmodule

// File: rtl/fthr_readback.sv
module fthr_readback
   import fifo_thr_pkg::*;
#(
   parameter int OFS_W = 14
) (
   input  logic             rclk,
   input  logic             mrst,
   input  logic             prst,
   input  logic             ld,
   input  logic             ren,
   input  logic [OFS_W-1:0] ae_ofs,
   input  logic [OFS_W-1:0] af_ofs,
   output logic [OFS_W-1:0] rb_data
);
   ofs_pick_e pick;

   always_ff @(posedge rclk) begin
      if (mrst) begin
         rb_data <= '0;
         pick    <= PICK_AE;
      end else if (prst) begin
         pick    <= PICK_AE;
      end else if (ld && ren) begin
         rb_data <= (pick == PICK_AE) ? ae_ofs : af_ofs;
         pick    <= (pick == PICK_AE) ? PICK_AF : PICK_AE;
      end
   end

   // R5: readback bus holds outside readback strobes
   a_r5_hold: assert property (@(posedge rclk) disable iff (mrst)
      (prst || !(ld && ren)) |=> $stable(rb_data));
endmodule

// File: rtl/fthr_cmp.sv
module fthr_cmp #(
   parameter int   CNT_W   = 14,
   parameter int   OFS_W   = 14,
   parameter bit   REG_OUT = 1'b1,
   parameter logic RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] count,
   input  logic [OFS_W-1:0] thr,
   output logic             flag
);
   localparam int CMP_W = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 1;

   logic hit;
   assign hit = CMP_W'(count) <= CMP_W'(thr);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) flag <= RST_VAL;
         else     flag <= hit;
      end
      // R6 R7: zero count always trips the flag one edge later
      a_r6_zero_trips: assert property (@(posedge clk) disable iff (rst)
         (count == '0) |=> flag);
   end else begin : g_comb
      always_comb flag = rst ? RST_VAL : hit;
      a_r7_zero_trips: assert property (@(posedge clk) disable iff (rst)
         (count == '0) |-> flag);
   end
endmodule

// File: rtl/fifo_thresh_flags.sv
module fifo_thresh_flags
   import fifo_thr_pkg::*;
#(
   parameter int OFS_W    = 14,
   parameter int DEPTH    = 8192,
   parameter int DFLT_LO  = 127,
   parameter int DFLT_HI  = 1023,
   parameter bit FLAG_REG = 1'b1,
   localparam int LVL_W   = $clog2(DEPTH + 1)
) (
   input  logic             wclk,
   input  logic             rclk,
   input  logic             mrst,
   input  logic             prst,
   input  logic             ld,
   input  logic             sen,
   input  logic             sin,
   input  logic             wen,
   input  logic [OFS_W-1:0] din,
   input  logic             ren,
   input  logic [LVL_W-1:0] wr_level,
   input  logic [LVL_W-1:0] rd_level,
   output logic             almost_empty,
   output logic             almost_full,
   output logic [OFS_W-1:0] rb_data,
   output logic             wr_advance,
   output logic             rd_advance
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("fifo_thresh_flags: DEPTH must be at least 2");
   end
   if (OFS_W < $clog2(DFLT_HI + 1) || OFS_W < $clog2(DFLT_LO + 1)) begin : g_bad_ofs
      $error("fifo_thresh_flags: OFS_W too narrow for defaults");
   end

   logic [OFS_W-1:0] ae_ofs;
   logic [OFS_W-1:0] af_ofs;
   load_mode_e       mode;
   logic [LVL_W-1:0] wr_free;
   logic             rst_any;

   assign rst_any    = mrst || prst;
   assign wr_free    = LVL_W'(DEPTH) - wr_level;
   assign wr_advance = wen && !ld;
   assign rd_advance = ren && !ld;

   fthr_ofs_regs #(.OFS_W(OFS_W), .DFLT_LO(DFLT_LO), .DFLT_HI(DFLT_HI)) u_regs (
      .wclk(wclk), .mrst(mrst), .prst(prst), .ld(ld), .sen(sen), .sin(sin),
      .wen(wen), .din(din), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .mode(mode)
   );

   fthr_readback #(.OFS_W(OFS_W)) u_rb (
      .rclk(rclk), .mrst(mrst), .prst(prst), .ld(ld), .ren(ren),
      .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rb_data(rb_data)
   );

   fthr_cmp #(.CNT_W(LVL_W), .OFS_W(OFS_W), .REG_OUT(FLAG_REG), .RST_VAL(1'b1)) u_ae (
      .clk(rclk), .rst(rst_any), .count(rd_level), .thr(ae_ofs), .flag(almost_empty)
   );

   fthr_cmp #(.CNT_W(LVL_W), .OFS_W(OFS_W), .REG_OUT(FLAG_REG), .RST_VAL(1'b0)) u_af (
      .clk(wclk), .rst(rst_any), .count(wr_free), .thr(af_ofs), .flag(almost_full)
   );

   // R7: write-side level never exceeds capacity
   a_r7_level_range: assert property (@(posedge wclk) disable iff (mrst)
      wr_level <= LVL_W'(DEPTH));
   // R9: no pointer advance while loading
   a_r9_hold_wr: assert property (@(posedge wclk) disable iff (mrst)
      ld |-> !wr_advance);
   a_r9_hold_rd: assert property (@(posedge rclk) disable iff (mrst)
      ld |-> !rd_advance);
   // R10: flags in reset state
   a_r10_af_low: assert property (@(posedge wclk)
      $past(rst_any) && rst_any |-> !almost_full);
endmodule

// File: tb/fifo_thresh_flags_test.sv
`timescale 1ns/100ps
module fifo_thresh_flags_test;
   localparam int W     = 10;
   localparam int DEPTH = 1024;
   localparam int LW    = 11;

   logic wclk = 0, rclk = 0;
   logic mrst = 1, prst = 0, ld = 0, sen = 0, sin = 0, wen = 0, ren = 0;
   logic [W-1:0]  din = '0;
   logic [LW-1:0] wr_level = '0, rd_level = '0;
   logic almost_empty, almost_full, wr_advance, rd_advance;
   logic [W-1:0] rb_data;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   fifo_thresh_flags #(.OFS_W(W), .DEPTH(DEPTH)) uut (
      .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .ld(ld), .sen(sen),
      .sin(sin), .wen(wen), .din(din), .ren(ren), .wr_level(wr_level),
      .rd_level(rd_level), .almost_empty(almost_empty), .almost_full(almost_full),
      .rb_data(rb_data), .wr_advance(wr_advance), .rd_advance(rd_advance)
   );

   always #2.5 wclk = ~wclk;
   initial begin
      #1.2;
      forever #2.5 rclk = ~rclk;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         finish_run();
      end
   end

   task automatic do_mrst(input logic ldv);
      ld = ldv; mrst = 1;
      repeat (3) @(posedge wclk);
      repeat (3) @(posedge rclk);
      @(posedge wclk); #1;
      mrst = 0; ld = 0;
   endtask

   task automatic do_prst();
      @(posedge wclk); #1;
      prst = 1;
      repeat (3) @(posedge wclk);
      repeat (2) @(posedge rclk);
      @(posedge wclk); #1;
      prst = 0;
   endtask

   task automatic wload(input logic [W-1:0] v);
      @(posedge wclk); #1;
      ld = 1; wen = 1; din = v;
      @(posedge wclk); #1;
      ld = 0; wen = 0;
   endtask

   task automatic sbit(input logic b);
      @(posedge wclk); #1;
      ld = 1; sen = 1; sin = b;
      @(posedge wclk); #1;
      ld = 0; sen = 0;
   endtask

   task automatic sword(input logic [W-1:0] v);
      for (int i = 0; i < W; i++) sbit(v[i]);
   endtask

   task automatic rback(output logic [W-1:0] v);
      @(posedge rclk); #1;
      ld = 1; ren = 1;
      @(posedge rclk); #1;
      ld = 0; ren = 0;
      v = rb_data;
   endtask

   task automatic expect_pair(input int ae, input int af, input string req);
      logic [W-1:0] v;
      rback(v); check(v == W'(ae), req, v, ae);
      rback(v); check(v == W'(af), req, v, af);
   endtask

   task automatic sweep_ae(input int thr);
      for (int l = 0; l <= DEPTH; l++) begin
         @(posedge rclk); #1; rd_level = LW'(l);
         @(posedge rclk); #1;
         check(almost_empty == (l <= thr), "R6", almost_empty, int'(l <= thr));
      end
   endtask

   task automatic sweep_af(input int thr);
      for (int l = 0; l <= DEPTH; l++) begin
         @(posedge wclk); #1; wr_level = LW'(l);
         @(posedge wclk); #1;
         check(almost_full == ((DEPTH - l) <= thr), "R7", almost_full, int'((DEPTH - l) <= thr));
      end
   endtask

   initial begin
      logic [W-1:0] v;
      // R10: flags during reset with levels that would flip them
      rd_level = LW'(1000); wr_level = LW'(1024);
      ld = 0;
      repeat (4) @(posedge wclk);
      #1;
      check(almost_empty == 1'b1, "R10", almost_empty, 1);
      check(almost_full == 1'b0, "R10", almost_full, 0);
      check(rb_data == '0, "R1", rb_data, 0);
      do_mrst(1'b0);
      @(posedge rclk); @(posedge wclk); #1;
      check(almost_empty == 1'b0, "R6", almost_empty, 0);
      check(almost_full == 1'b1, "R7", almost_full, 1);
      // R1: word mode defaults
      expect_pair(127, 127, "R1");
      // R2: alternating word loads
      wload(W'(300)); wload(W'(45));
      expect_pair(300, 45, "R2");
      // R4: serial strobes ignored in word mode
      for (int i = 0; i < 6; i++) sbit(1'b1);
      expect_pair(300, 45, "R4");
      // R5: bus holds without a full readback strobe
      rback(v);
      @(posedge rclk); #1; ld = 1; ren = 0;
      @(posedge rclk); #1; ld = 0; ren = 1;
      @(posedge rclk); #1; ren = 0;
      check(rb_data == W'(300), "R5", rb_data, 300);
      rback(v); check(v == W'(45), "R5", v, 45);
      // R6 / R7 sweeps
      sweep_ae(300);
      sweep_af(45);
      // R9 combinational gating
      for (int k = 0; k < 4; k++) begin
         @(posedge wclk); #1;
         ld = k[0]; wen = k[1]; ren = k[1];
         #0.5;
         check(wr_advance == (k[1] && !k[0]), "R9", wr_advance, int'(k[1] && !k[0]));
         check(rd_advance == (k[1] && !k[0]), "R9", rd_advance, int'(k[1] && !k[0]));
         ld = 0;
      end
      wen = 0; ren = 0;
      // R8: partial reset restarts order, keeps values and mode
      wload(W'(512));
      rback(v);
      rd_level = LW'(0); wr_level = LW'(0);
      do_prst();
      wload(W'(77));
      sbit(1'b1); sbit(1'b0);
      expect_pair(77, 45, "R8");
      // R1: bit-serial mode defaults
      do_mrst(1'b1);
      expect_pair(1023, 1023, "R1");
      // R3: serial chain
      sword(W'(613)); sword(W'(90));
      expect_pair(613, 90, "R3");
      // R3: wrap back to first chain bit
      sword(W'(5));
      expect_pair(5, 90, "R3");
      sword(W'(200));
      // R4: word strobes ignored in serial mode
      wload(W'(11)); wload(W'(22));
      expect_pair(5, 200, "R4");
      // R8: partial serial run then partial reset
      sbit(1'b1); sbit(1'b1); sbit(1'b1);
      do_prst();
      sword(W'(258));
      wload(W'(33));
      expect_pair(258, 200, "R8");
      sweep_ae(258);
      done = 1;
      finish_run();
   end
endmodule